// File: doc/BRIEF.md
# Handshake Line Interrupt Priority Controller

This block sits on the peripheral side of a processor bus and watches four handshake input lines, H1 to H4. Each line is synchronized and checked for an edge toward its programmed active sense. A qualifying edge sets a sticky flag that software later clears by writing a one to it. Lines are enabled in pairs, H1/H2 and H3/H4, and each line also has its own interrupt enable.

Pending flags with their interrupt enable set compete for service. The winner is chosen by one of eight fixed priority permutations. The block raises an interrupt request. When the acknowledge strobe arrives, it answers in one of two ways. In vectored mode it returns a vector byte: six user bits with a two-bit source code in the low bits. In autovectored mode it raises an autovector indication and returns no vector.

Registers are byte wide: control at address 0, service request at 1, vector at 2, status at 3, and interrupt enable at 4.

Top module: `hs_irq_ctrl`

## Requirements
- R1: Each line passes through a two-flop synchronizer. An edge toward the active sense sets the line's flag, and an edge away from it does not. Control bit n (n=0..3 for H1..H4) selects the sense: 1 means active high, 0 means active low. The flag for Hn+1 is status bit n.
- R2: Control bit 4 enables the H1/H2 pair and control bit 5 enables the H3/H4 pair. A line in a disabled pair sets no flag and requests no interrupt.
- R3: Flags are sticky. Writing 1 to status bit n clears flag n. Writing 0 leaves it unchanged.
- R4: Service-request bits 2:0 select the priority order. The eight orders are: 000 H1>H2>H3>H4, 001 H2>H1>H3>H4, 010 H1>H2>H4>H3, 011 H2>H1>H4>H3, 100 H3>H4>H1>H2, 101 H3>H4>H2>H1, 110 H4>H3>H1>H2, 111 H4>H3>H2>H1.
- R5: Service-request bits 4:3 select the mode: 00 no interrupt, 01 autovectored, 10 or 11 vectored. In mode 00, irq_o stays low.
- R6: In vectored mode, an acknowledge while a request is pending produces vec_valid_o for one cycle, in the cycle after iack_i. vec_o then carries vector register bits 7:2 in its upper bits and the winner's code in bits 1:0 (H1=00, H2=01, H3=10, H4=11).
- R7: In autovectored mode, an acknowledge produces autovec_o in the cycle after iack_i, and vec_valid_o stays low.
- R8: Status bits 7, 6, 5 and 4 read the synchronized live levels of H4, H3, H2 and H1.
- R9: Interrupt-enable register bit n gates line Hn+1. A flag with its enable clear is still set and readable, but it takes no part in arbitration and does not raise irq_o.
- R10: After reset, all registers, flags, irq_o, vec_valid_o and autovec_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| hs_i | input | 4 | Handshake lines, bit 0 = H1 |
| irq_o | output | 1 | Interrupt request |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| vec_valid_o | output | 1 | Vector byte valid |
| vec_o | output | 8 | Vector byte |
| autovec_o | output | 1 | Autovector indication |

## Verification
All four flags are held pending together. Each of the eight orders is then tried under several enable masks. A swapped pair or reversed group in the rank table would therefore return the wrong source code. The bench drives edges away from the active sense and lines in a disabled pair. A design that ignored polarity or pair enables would set flags there. It also writes zero bits to the status register, which a wrong clear would treat as clears. Finally, it checks that autovectored mode gives no vector byte and that mode 00 keeps the request low even with flags pending.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int NLINES = 4;
  localparam int AW     = 3;
  localparam int DW     = 8;
  localparam int SRCW   = $clog2(NLINES);

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_SVC  = 3'd1;
  localparam logic [AW-1:0] A_VEC  = 3'd2;
  localparam logic [AW-1:0] A_STAT = 3'd3;
  localparam logic [AW-1:0] A_IEN  = 3'd4;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_AUTO = 2'b01,
    MODE_VEC0 = 2'b10,
    MODE_VEC1 = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] sense_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    // edge toward active sense only
    assign hit_o[i] = sense_i[i] ? (s2_q[i] & ~prev_q[i]) : (~s2_q[i] & prev_q[i]);
  end

  assign level_o = s2_q;
endmodule

// File: rtl/hs_prio_arb.sv
module hs_prio_arb
  import hs_pkg::*;
(
  input  logic [NLINES-1:0] req_i,
  input  logic [2:0]        order_i,
  output logic              any_o,
  output logic [SRCW-1:0]   src_o
);
  logic [SRCW-1:0] rank [NLINES];
  logic [SRCW-1:0] f12, s12, f34, s34;

  // bit0 swaps H1/H2, bit1 swaps H3/H4, bit2 puts H3/H4 group first
  always_comb begin
    f12 = order_i[0] ? 2'd1 : 2'd0;
    s12 = order_i[0] ? 2'd0 : 2'd1;
    f34 = order_i[1] ? 2'd3 : 2'd2;
    s34 = order_i[1] ? 2'd2 : 2'd3;
    if (order_i[2]) begin
      rank[0] = f34; rank[1] = s34; rank[2] = f12; rank[3] = s12;
    end else begin
      rank[0] = f12; rank[1] = s12; rank[2] = f34; rank[3] = s34;
    end
  end

  always_comb begin
    any_o = 1'b0;
    src_o = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (req_i[rank[i]]) begin
        any_o = 1'b1;
        src_o = rank[i];
      end
    end
  end

  always_comb begin
    if (any_o) begin
      a_grant_requested_r4: assert (req_i[src_o]);
    end
  end
endmodule

// File: rtl/hs_irq_ctrl.sv
module hs_irq_ctrl
  import hs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [3:0]    hs_i,
  output logic          irq_o,
  input  logic          iack_i,
  output logic          vec_valid_o,
  output logic [DW-1:0] vec_o,
  output logic          autovec_o
);
  logic [DW-1:0]     ctrl_q, svc_q, vecr_q;
  logic [NLINES-1:0] ien_q, flag_q;
  logic [NLINES-1:0] level, hit, pair_en, clr_w, req;
  logic              any_req;
  logic [SRCW-1:0]   src;
  irq_mode_e         mode;

  hs_sync_edge #(.N(NLINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (hs_i),
    .sense_i (ctrl_q[NLINES-1:0]),
    .level_o (level),
    .hit_o   (hit)
  );

  assign pair_en = {ctrl_q[5], ctrl_q[5], ctrl_q[4], ctrl_q[4]};
  assign clr_w   = (we_i && addr_i == A_STAT) ? wdata_i[NLINES-1:0] : '0;
  assign req     = flag_q & ien_q & pair_en;
  assign mode    = irq_mode_e'(svc_q[4:3]);

  hs_prio_arb u_arb (
    .req_i   (req),
    .order_i (svc_q[2:0]),
    .any_o   (any_req),
    .src_o   (src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      svc_q  <= '0;
      vecr_q <= '0;
      ien_q  <= '0;
      flag_q <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          A_CTRL:  ctrl_q <= wdata_i;
          A_SVC:   svc_q  <= wdata_i;
          A_VEC:   vecr_q <= wdata_i;
          A_IEN:   ien_q  <= wdata_i[NLINES-1:0];
          default: ;
        endcase
      end
      // a new edge wins over a same-cycle clear
      flag_q <= (flag_q & ~clr_w) | (hit & pair_en);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      autovec_o   <= 1'b0;
      vec_o       <= '0;
    end else begin
      vec_valid_o <= iack_i && any_req && mode[1];
      autovec_o   <= iack_i && any_req && (mode == MODE_AUTO);
      if (iack_i && any_req && mode[1])
        vec_o <= {vecr_q[DW-1:SRCW], src};
    end
  end

  assign irq_o = (mode != MODE_OFF) && any_req;

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_SVC:   rdata_o = svc_q;
      A_VEC:   rdata_o = vecr_q;
      A_STAT:  rdata_o = {level, flag_q};
      A_IEN:   rdata_o = {{(DW-NLINES){1'b0}}, ien_q};
      default: rdata_o = '0;
    endcase
  end

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_w)) == $past(flag_q & ~clr_w)));

  p_pair12_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[4] && flag_q[1:0] == 2'b00) |=> (flag_q[1:0] == 2'b00));

  p_pair34_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[5] && flag_q[3:2] == 2'b00) |=> (flag_q[3:2] == 2'b00));

  p_mode_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_q[4:3] == 2'b00) |-> !irq_o);

  p_ack_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_valid_o && autovec_o));

  p_vec_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> (vec_o[DW-1:SRCW] == $past(vecr_q[DW-1:SRCW])));

  p_ien_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/sim_hs_irq_ctrl.sv
module sim_hs_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] hs = '0;
  logic       irq, iack = 1'b0, vvalid, autov;
  logic [7:0] vec;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hs_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .hs_i(hs), .irq_o(irq), .iack_i(iack),
    .vec_valid_o(vvalid), .vec_o(vec), .autovec_o(autov)
  );

  // {order[2:0], enable mask[3:0], expected source[1:0]}
  localparam logic [8:0] TBL [14] = '{
    {3'd0, 4'hF, 2'd0}, {3'd1, 4'hF, 2'd1}, {3'd2, 4'hF, 2'd0}, {3'd3, 4'hF, 2'd1},
    {3'd4, 4'hF, 2'd2}, {3'd5, 4'hF, 2'd2}, {3'd6, 4'hF, 2'd3}, {3'd7, 4'hF, 2'd3},
    {3'd0, 4'hC, 2'd2}, {3'd2, 4'hC, 2'd3}, {3'd5, 4'h3, 2'd1}, {3'd6, 4'h3, 2'd0},
    {3'd7, 4'h3, 2'd1}, {3'd4, 4'h3, 2'd0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic drive(input logic [3:0] v);
    @(negedge clk); hs = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack;
    @(negedge clk); iack = 1'b1;
    @(negedge clk); iack = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10 reset state
    for (int a = 0; a < 5; a++) rd_chk("R10", 3'(a), 8'h00);
    chk("R10 irq", {7'd0, irq}, 8'h00);
    chk("R10 ack", {6'd0, vvalid, autov}, 8'h00);

    wr(3'd0, 8'h3F);
    wr(3'd2, 8'hA7);
    wr(3'd1, 8'h10);
    drive(4'hF);
    rd_chk("R1 R8 all rising", 3'd3, 8'hFF);

    // R4 R6 priority table
    for (int i = 0; i < 14; i++) begin
      wr(3'd4, {4'd0, TBL[i][5:2]});
      wr(3'd1, {3'd0, 2'b10, TBL[i][8:6]});
      ack();
      chk("R6 valid", {6'd0, vvalid, autov}, 8'h02);
      chk("R4 R6 vector", vec, {6'b101001, TBL[i][1:0]});
    end

    // R6 one-cycle response
    @(negedge clk);
    chk("R6 single cycle", {7'd0, vvalid}, 8'h00);

    // R5 mode off
    wr(3'd1, 8'h00);
    @(negedge clk); chk("R5 mode off", {7'd0, irq}, 8'h00);
    ack();
    chk("R5 no response", {6'd0, vvalid, autov}, 8'h00);

    // R7 autovectored
    wr(3'd1, 8'h08);
    @(negedge clk); chk("R7 irq", {7'd0, irq}, 8'h01);
    ack();
    chk("R7 autovec", {6'd0, vvalid, autov}, 8'h01);

    // R9 enable gating
    wr(3'd4, 8'h00);
    @(negedge clk); chk("R9 gated irq", {7'd0, irq}, 8'h00);
    rd_chk("R9 flags still set", 3'd3, 8'hFF);

    // R3 write-1 clear, write-0 no effect
    wr(3'd3, 8'hF0);
    rd_chk("R3 zero write", 3'd3, 8'hFF);
    wr(3'd3, 8'h01);
    rd_chk("R3 clear H1", 3'd3, 8'hFE);
    wr(3'd3, 8'h0F);
    rd_chk("R3 clear all", 3'd3, 8'hF0);

    // R1 edge away from active-high sets nothing
    drive(4'h0);
    rd_chk("R1 falling ignored", 3'd3, 8'h00);
    // R1 active-low on H1
    wr(3'd0, 8'h3E);
    drive(4'h1);
    rd_chk("R1 R8 rise on low sense", 3'd3, 8'h10);
    drive(4'h0);
    rd_chk("R1 fall on low sense", 3'd3, 8'h01);
    wr(3'd3, 8'h0F);

    // R2 pair H1/H2 disabled
    wr(3'd0, 8'h2F);
    wr(3'd4, 8'h0F);
    wr(3'd1, 8'h10);
    drive(4'h7);
    rd_chk("R2 pair off", 3'd3, 8'h74);
    ack();
    chk("R2 only H3 served", vec, 8'hA6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule